// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether an incoming multicast destination address passes a hash filter. A 2-bit window mode picks twelve bits out of the upper two bytes of the 48-bit destination address. That 12-bit hash vector addresses a 4096-bit table, which software loads one 32-bit word at a time. A control write sets the window mode and a global hash enable.

For every destination address presented with a strobe, the block reports one clock later whether the address is multicast and whether it hits a set bit of the table. A hit needs all three of these: the enable is set, the address is multicast, and the selected table bit is 1.

A small result state machine tracks the report. `RS_IDLE` means no result is shown. `RS_REPORT` means a result is shown for the strobe of the previous cycle. The transitions are:
- IDLE_TO_REPORT, taken on a strobe from `RS_IDLE`.
- REPORT_HOLD, taken on a strobe from `RS_REPORT`.
- REPORT_TO_IDLE, taken from `RS_REPORT` when there is no strobe.

Top module: `mhf_filter`

## Requirements
- R1: After reset every table bit is 0, the enable is clear, the mode is 0 and all result outputs are 0.
- R2: `res_mcast` equals bit 0 of address byte 0 (`lk_addr[0]`). Byte k of the address is `lk_addr[8k+7:8k]`.
- R3: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high. While `res_valid` is 0, `res_mcast` and `res_hit` are 0.
- R4: In mode 0 the hash vector is {byte5[7:0], byte4[7:4]}.
- R5: In mode 1 the hash vector is {byte5[6:0], byte4[7:3]}.
- R6: In mode 2 the hash vector is {byte5[5:0], byte4[7:2]}.
- R7: In mode 3 the hash vector is {byte5[3:0], byte4[7:0]}.
- R8: Vector bits 11:5 select the table word and vector bits 4:0 select the bit inside that word.
- R9: With the enable clear, `res_hit` is 0 for every lookup.
- R10: A lookup of a non-multicast address never gives `res_hit` = 1.
- R11: A table word or control write in the same cycle as a lookup affects only later lookups.
- R12: A table write replaces the whole word: bit j of `wr_data` becomes bit j of word `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table word write strobe |
| wr_idx | input | 7 | Index of the table word being written |
| wr_data | input | 32 | Table word value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_mode | input | 2 | Window mode, 0 to 3 |
| ctrl_en | input | 1 | Global hash enable |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | A result is shown |
| res_mcast | output | 1 | The looked-up address is multicast |
| res_hit | output | 1 | Hash accept |

## Verification
Directed lookups place a single set bit at the first word, the last word and bit 31, one case for each mode. These show whether each window slice and the word/bit split are wired correctly. Random addresses, looked up against densely filled random words under random modes, vary which bits fall inside and outside each window. This separates modes that would otherwise alias. Non-multicast addresses and a cleared enable are mixed in to show that the hit flag is gated by both conditions. A write and a lookup on the same word in one cycle show which table value the lookup used.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int ADDR_W = 48;
    localparam int VEC_W  = 12;
    localparam int WORD_W = 32;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int IDX_W  = VEC_W - BIT_W;
    localparam int WORDS  = 2 ** IDX_W;
    localparam int MODE_W = 2;

    typedef enum logic [0:0] {RS_IDLE = 1'b0, RS_REPORT = 1'b1} rs_state_t;

    typedef struct packed {
        logic              en;
        logic [MODE_W-1:0] mode;
    } mhf_ctrl_t;
endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              en_in,
    output mhf_ctrl_t         ctrl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl.en   <= en_in;
            ctrl.mode <= mode_in;
        end
    end
endmodule

// File: rtl/mhf_vsel.sv
module mhf_vsel
    import mhf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [VEC_W-1:0]  vec
);
    // Upper two bytes of the address; each mode takes a 12-bit slice.
    logic [15:0] hi;
    assign hi = addr[ADDR_W-1 -: 16];

    always_comb begin
        unique case (mode)
            2'd0: vec = hi[15:4];
            2'd1: vec = hi[14:3];
            2'd2: vec = hi[13:2];
            2'd3: vec = hi[11:0];
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/mhf_table.sv
module mhf_table
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [VEC_W-1:0]  rd_vec,
    output logic              rd_bit
);
    logic [WORD_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(w))) begin
                mem[w] <= wr_data;
            end
        end
    end

    logic [WORD_W-1:0] sel_word;
    assign sel_word = mem[rd_vec[VEC_W-1:BIT_W]];
    assign rd_bit   = sel_word[rd_vec[BIT_W-1:0]];
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ctrl_we,
    input  logic [MODE_W-1:0] ctrl_mode,
    input  logic              ctrl_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_mcast,
    output logic              res_hit
);
    mhf_ctrl_t        cur_ctrl;
    logic [VEC_W-1:0] vec;
    logic             tbl_bit;
    rs_state_t        st, nxt;
    logic             mc_q, hit_q;

    mhf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we),
        .mode_in(ctrl_mode), .en_in(ctrl_en), .ctrl(cur_ctrl)
    );

    mhf_vsel u_vsel (.mode(cur_ctrl.mode), .addr(lk_addr), .vec(vec));

    mhf_table u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_vec(vec), .rd_bit(tbl_bit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= RS_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RS_IDLE:   if (lk_valid)  nxt = RS_REPORT;
            RS_REPORT: if (!lk_valid) nxt = RS_IDLE;
            default:   nxt = RS_IDLE;
        endcase
    end

    // Output process: capture the result of the current strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q  <= 1'b0;
            hit_q <= 1'b0;
        end else if (lk_valid) begin
            mc_q  <= lk_addr[0];
            hit_q <= lk_addr[0] & cur_ctrl.en & tbl_bit;
        end
    end

    assign res_valid = (st == RS_REPORT);
    assign res_mcast = res_valid & mc_q;
    assign res_hit   = res_valid & hit_q;
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk
    import mhf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              cur_en,
    input logic              res_valid,
    input logic              res_mcast,
    input logic              res_hit
);
    // R3
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    // R3
    no_strobe_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    // R3
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_mcast && !res_hit));
    // R2
    mcast_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_mcast == $past(lk_addr[0])));
    // R10
    unicast_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[0]) |=> !res_hit);
    // R9
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !cur_en) |=> !res_hit);
endmodule

bind mhf_filter mhf_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .cur_en(cur_ctrl.en), .res_valid(res_valid), .res_mcast(res_mcast),
    .res_hit(res_hit)
);

// File: tb/sim_mhf_filter.sv
module sim_mhf_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        ctrl_we = 1'b0;
    logic [1:0]  ctrl_mode = '0;
    logic        ctrl_en = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid, res_mcast, res_hit;

    int checks = 0;
    int fails = 0;
    logic [31:0] mdl [128];
    logic        m_en = 1'b0;
    logic [1:0]  m_mode = '0;

    always #2 clk = ~clk;

    mhf_filter u0 (.*);

    function automatic logic [11:0] vec_of(input logic [1:0] md, input logic [47:0] a);
        logic [7:0] b5 = a[47:40];
        logic [7:0] b4 = a[39:32];
        case (md)
            2'd0: return {b5, b4[7:4]};
            2'd1: return {b5[6:0], b4[7:3]};
            2'd2: return {b5[5:0], b4[7:2]};
            default: return {b5[3:0], b4};
        endcase
    endfunction

    function automatic logic exp_hit(input logic [47:0] a);
        logic [11:0] v = vec_of(m_mode, a);
        return m_en & a[0] & mdl[v[11:5]][v[4:0]];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [6:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[i] = d;
    endtask

    task automatic set_ctrl(input logic en, input logic [1:0] md);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_en = en; ctrl_mode = md;
        @(negedge clk);
        ctrl_we = 1'b0;
        m_en = en; m_mode = md;
    endtask

    task automatic lookup(input string req, input logic [47:0] a);
        logic e;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        e = exp_hit(a);
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, res_valid, 1'b1);
        chk({req, " mcast"}, res_mcast, a[0]);
        chk({req, " hit"}, res_hit, e);
    endtask

    // address whose window in mode md gives vector v, multicast bit set
    function automatic logic [47:0] addr_for(input logic [1:0] md, input logic [11:0] v);
        logic [15:0] hi;
        case (md)
            2'd0: hi = {v, 4'h0};
            2'd1: hi = {1'b0, v, 3'h0};
            2'd2: hi = {2'b0, v, 2'h0};
            default: hi = {4'h0, v};
        endcase
        return {hi, 32'h0000_0001};
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [11:0] v;
        for (int i = 0; i < 128; i++) mdl[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", res_valid, 1'b0);
        chk("R1 res_hit", res_hit, 1'b0);
        set_ctrl(1'b1, 2'd3);
        lookup("R1 table zero", 48'hFFFF_0000_0001);

        // R4..R7 and R8 directed: one bit at corners of the table
        for (int md = 0; md < 4; md++) begin
            for (int k = 0; k < 3; k++) begin
                v = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : 12'h53F;
                wr_word(v[11:5], 32'h1 << v[4:0]);
                set_ctrl(1'b1, 2'(md));
                case (md)
                    0: lookup("R4 mode0 R8", addr_for(2'd0, v));
                    1: lookup("R5 mode1 R8", addr_for(2'd1, v));
                    2: lookup("R6 mode2 R8", addr_for(2'd2, v));
                    default: lookup("R7 mode3 R8", addr_for(2'd3, v));
                endcase
                // neighbour bit must miss
                lookup("R8 neighbour", addr_for(2'(md), v ^ 12'h001));
                wr_word(v[11:5], 32'h0);
            end
        end

        // R12 whole-word replace
        wr_word(7'd9, 32'hFFFF_FFFF);
        wr_word(7'd9, 32'h0000_0004);
        set_ctrl(1'b1, 2'd3);
        lookup("R12 replaced bit", addr_for(2'd3, {7'd9, 5'd0}));
        lookup("R12 kept bit", addr_for(2'd3, {7'd9, 5'd2}));

        // R9 enable gate
        set_ctrl(1'b0, 2'd3);
        lookup("R9 disabled", addr_for(2'd3, {7'd9, 5'd2}));
        // R10 unicast
        set_ctrl(1'b1, 2'd3);
        lookup("R10 unicast", addr_for(2'd3, {7'd9, 5'd2}) & ~48'h1);

        // R11 same-cycle write and lookup
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 7'd20; wr_data = 32'h8000_0000;
        lk_valid = 1'b1; lk_addr = addr_for(2'd3, {7'd20, 5'd31});
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        mdl[20] = 32'h8000_0000;
        chk("R11 old table used", res_hit, 1'b0);
        lookup("R11 later lookup", addr_for(2'd3, {7'd20, 5'd31}));
        // R11 same-cycle control write
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_en = 1'b0; ctrl_mode = 2'd3;
        lk_valid = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0; lk_valid = 1'b0; m_en = 1'b0;
        chk("R11 old enable used", res_hit, 1'b1);
        @(negedge clk);
        chk("R3 idle after strobe", res_valid, 1'b0);
        chk("R3 quiet mcast", res_mcast, 1'b0);

        // random mix (R2 R4 R5 R6 R7 R9 R10)
        for (int i = 0; i < 128; i++) wr_word(7'(i), $urandom);
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0) set_ctrl(($urandom % 5) != 0, 2'($urandom));
            if (n % 7 == 0) wr_word(7'($urandom), $urandom);
            lookup("R2 random", {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule